// File: doc/BRIEF.md
# Serial Nonvolatile-Memory Slave Controller

This block lets a 256-byte on-chip array answer on a four-wire SPI bus as if it were a small serial nonvolatile memory. A host drops chip select, shifts in an opcode, and then sends an address and data or reads bytes back. The host can also set or clear a write-enable latch, and it can read or load a status byte. Two more pins let the host pause a transfer (hold) and lock out all writes (write protect). All pins are brought into the system clock domain through two-flop synchronizers. The SPI clock must therefore run several times slower than the system clock; the bench uses at least ten system cycles per SPI bit.

Write data goes into a 4-byte page buffer. The buffer is committed to the array only when chip select rises on a byte boundary. After a commit the block stays busy for a programmable number of system clock cycles, standing in for the self-timed write of a real cell. A two-bit protection field in the status byte shields the top quarter, the top half or the whole array.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset every array location reads 0xFF, the status byte reads 0x00 and SO is not driven (so_en low).
- R2: so_en is high only while cs_n is low and hold_n is high. Otherwise SO is treated as high-impedance.
- R3: SPI modes 0 and 3 both work. SI is captured on each rising SCK edge and SO changes on each falling edge, most significant bit first. The first bit of a reply appears on the falling edge that follows the last rising edge of the previous byte.
- R4: The opcodes are 0x06 (set latch), 0x04 (clear latch), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). After any other opcode, the block ignores the bytes that follow until cs_n goes high.
- R5: The status byte holds busy in bit 0, the write-enable latch in bit 1, the protection field in bits 3:2 and zeros in bits 7:4. A status read returns a fresh status byte in every byte slot. A status write takes only bits 3:2.
- R6: The write-enable latch is 0 after reset. It is set by 0x06 and cleared by 0x04, and it is cleared by every accepted write or status write. A write or status write sent while the latch is 0 changes nothing.
- R7: A read sends one address byte and then returns data bytes from consecutive addresses, wrapping from 0xFF to 0x00.
- R8: Write data bytes fill the aligned 4-byte page named by the address, starting at its low two bits. The offset wraps within the page, so a later byte overwrites an earlier one at the same offset. Locations of the page that were never loaded keep their contents.
- R9: A write or status write is committed only when cs_n rises with a whole number of bytes shifted and at least one data byte received. A cs_n rise in the middle of a byte discards the command and leaves the latch set.
- R10: A commit makes busy read 1 for WR_CYCLES system cycles. While busy, every opcode except 0x05 is ignored.
- R11: Protection field 01 protects 0xC0..0xFF, 10 protects 0x80..0xFF and 11 protects all addresses. Bytes aimed at protected addresses are dropped, while unprotected bytes of the same page are still written.
- R12: While wp_n is low, writes and status writes are rejected, and the write-enable latch keeps its value.
- R13: While hold_n is low, edges on SCK and SI are ignored. After release the transfer continues from the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write lockout |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for SO; low means high-impedance |

## Verification
The hardest states to reach from the ports are the ones where timing and protocol state overlap. One is a command arriving while the self-timed write is still running. The other is a hold that lands in the middle of a byte. The bench sets the write time short enough to finish a status poll and a latch-set attempt inside the busy window, and then checks that the latch stayed clear once busy ends. Hold is asserted between two bit times, after the previous falling edge has settled. While hold is low the bench toggles SCK and SI an even number of times, and it then checks that the address and the read data still come out bit-exact.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_WSTAT,
        PH_RSTAT,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OPC_LATCH_ON  = 8'h06;
    localparam logic [7:0] OPC_LATCH_OFF = 8'h04;
    localparam logic [7:0] OPC_STAT_RD   = 8'h05;
    localparam logic [7:0] OPC_STAT_WR   = 8'h01;
    localparam logic [7:0] OPC_MEM_RD    = 8'h03;
    localparam logic [7:0] OPC_MEM_WR    = 8'h02;

    localparam logic [1:0] GUARD_NONE    = 2'b00;
    localparam logic [1:0] GUARD_QUARTER = 2'b01;
    localparam logic [1:0] GUARD_HALF    = 2'b10;
    localparam logic [1:0] GUARD_ALL     = 2'b11;
endpackage

// File: rtl/spi_mem_bitio.sv
`timescale 1ns/1ps
module spi_mem_bitio #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck,
    input  logic         si,
    input  logic         cs_n,
    input  logic         hold_n,
    input  logic [W-1:0] tx_byte,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid,
    output logic         at_boundary,
    output logic         cs_rise,
    output logic         so,
    output logic         so_en
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [1:0]    sck_sync;
        logic [1:0]    si_sync;
        logic [1:0]    cs_sync;
        logic [1:0]    hold_sync;
        logic          sck_prev;
        logic          cs_prev;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rx;
        logic [W-1:0]  tx;
        logic          so;
        logic          valid;
    } bit_st_t;

    bit_st_t s_d, s_q;
    logic live, rise, fall;

    always_comb begin
        s_d           = s_q;
        s_d.sck_sync  = {s_q.sck_sync[0], sck};
        s_d.si_sync   = {s_q.si_sync[0], si};
        s_d.cs_sync   = {s_q.cs_sync[0], cs_n};
        s_d.hold_sync = {s_q.hold_sync[0], hold_n};
        s_d.sck_prev  = s_q.sck_sync[1];
        s_d.cs_prev   = s_q.cs_sync[1];
        s_d.valid     = 1'b0;

        live = !s_q.cs_sync[1] && s_q.hold_sync[1];
        rise = live && s_q.sck_sync[1] && !s_q.sck_prev;
        fall = live && !s_q.sck_sync[1] && s_q.sck_prev;

        if (s_q.cs_sync[1]) begin
            s_d.cnt = '0;
        end else if (rise) begin
            s_d.rx  = {s_q.rx[W-2:0], s_q.si_sync[1]};
            s_d.cnt = s_q.cnt + CW'(1);
            if (s_q.cnt == LAST) s_d.valid = 1'b1;
        end

        if (fall) begin
            if (s_q.cnt == '0) begin
                s_d.so = tx_byte[W-1];
                s_d.tx = {tx_byte[W-2:0], 1'b0};
            end else begin
                s_d.so = s_q.tx[W-1];
                s_d.tx = {s_q.tx[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.cs_sync   <= 2'b11;
            s_q.cs_prev   <= 1'b1;
            s_q.hold_sync <= 2'b11;
            s_q.so        <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_byte     = s_q.rx;
    assign rx_valid    = s_q.valid;
    assign at_boundary = (s_q.cnt == '0);
    assign cs_rise     = s_q.cs_sync[1] && !s_q.cs_prev;
    assign so          = s_q.so;
    assign so_en       = live;
endmodule

// File: rtl/spi_mem_guard.sv
`timescale 1ns/1ps
module spi_mem_guard #(
    parameter int AW = 8,
    parameter int PW = 2
) (
    input  logic [1:0]       field,
    input  logic [AW-PW-1:0] page,
    output logic [(1<<PW)-1:0] lock
);
    import spi_mem_pkg::*;
    localparam int PAGE = 1 << PW;

    for (genvar i = 0; i < PAGE; i++) begin : g_byte
        localparam logic [PW-1:0] OFF = PW'(i);
        logic [AW-1:0] a;
        assign a = {page, OFF};
        assign lock[i] = (field == GUARD_ALL)
                      || (field == GUARD_HALF    && a[AW-1])
                      || (field == GUARD_QUARTER && a[AW-1:AW-2] == 2'b11);
    end
endmodule

// File: rtl/spi_mem_array.sv
`timescale 1ns/1ps
module spi_mem_array #(
    parameter int AW        = 8,
    parameter int PW        = 2,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data,
    input  logic                      start,
    input  logic [AW-PW-1:0]          wr_page,
    input  logic [(1<<PW)-1:0][DW-1:0] wr_bytes,
    input  logic [(1<<PW)-1:0]        wr_mask,
    output logic                      busy
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;
    localparam int TW    = $clog2(WR_CYCLES + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [TW-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start)              tmr_d = TW'(WR_CYCLES);
        else if (tmr_q != '0)   tmr_d = tmr_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (start) begin
            for (int i = 0; i < PAGE; i++)
                if (wr_mask[i]) mem[{wr_page, PW'(i)}] <= wr_bytes[i];
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (tmr_q != '0);
endmodule

// File: rtl/spi_mem_slave.sv
`timescale 1ns/1ps
module spi_mem_slave #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 2,
    parameter int WR_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);
    import spi_mem_pkg::*;
    localparam int PAGE = 1 << PAGE_W;
    localparam int DW   = BYTE_W;

    typedef struct packed {
        phase_e                   ph;
        logic                     rd_cmd;
        logic [ADDR_W-1:0]        addr;
        logic [PAGE-1:0][DW-1:0]  pbuf;
        logic [PAGE-1:0]          loaded;
        logic [1:0]               sr_new;
        logic                     sr_loaded;
        logic                     wel;
        logic [1:0]               field;
        logic [DW-1:0]            tx;
        logic [1:0]               wp_sync;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [DW-1:0]     rx_byte, rd_data, status_byte;
    logic              rx_valid, at_boundary, cs_rise, busy, commit, commit_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [PAGE-1:0]   lock, wr_mask;
    logic              wel_now;
    logic [1:0]        bp_now;

    spi_mem_bitio #(.W(DW)) u_bitio (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .tx_byte(r_q.tx), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .at_boundary(at_boundary), .cs_rise(cs_rise), .so(so), .so_en(so_en)
    );

    spi_mem_guard #(.AW(ADDR_W), .PW(PAGE_W)) u_guard (
        .field(r_q.field), .page(r_q.addr[ADDR_W-1:PAGE_W]), .lock(lock)
    );

    assign wr_mask = (r_q.ph == PH_WDATA) ? (r_q.loaded & ~lock) : '0;

    spi_mem_array #(.AW(ADDR_W), .PW(PAGE_W), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .start(commit), .wr_page(r_q.addr[ADDR_W-1:PAGE_W]), .wr_bytes(r_q.pbuf),
        .wr_mask(wr_mask), .busy(busy)
    );

    assign status_byte = {4'b0000, r_q.field, r_q.wel, busy};
    assign commit_ok   = at_boundary && r_q.wel && r_q.wp_sync[1] && !busy;

    always_comb begin
        r_d         = r_q;
        commit      = 1'b0;
        r_d.wp_sync = {r_q.wp_sync[0], wp_n};
        rd_addr     = r_q.addr;
        if (rx_valid && r_q.ph == PH_ADDR) rd_addr = rx_byte[ADDR_W-1:0];

        if (rx_valid) begin
            unique case (r_q.ph)
                PH_OPC: begin
                    r_d.ph        = PH_SKIP;
                    r_d.loaded    = '0;
                    r_d.sr_loaded = 1'b0;
                    if (busy) begin
                        if (rx_byte == OPC_STAT_RD) begin
                            r_d.ph = PH_RSTAT;
                            r_d.tx = status_byte;
                        end
                    end else begin
                        unique case (rx_byte)
                            OPC_LATCH_ON:  r_d.wel = 1'b1;
                            OPC_LATCH_OFF: r_d.wel = 1'b0;
                            OPC_STAT_RD: begin
                                r_d.ph = PH_RSTAT;
                                r_d.tx = status_byte;
                            end
                            OPC_STAT_WR:   r_d.ph = PH_WSTAT;
                            OPC_MEM_RD: begin
                                r_d.ph     = PH_ADDR;
                                r_d.rd_cmd = 1'b1;
                            end
                            OPC_MEM_WR: begin
                                r_d.ph     = PH_ADDR;
                                r_d.rd_cmd = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_ADDR: begin
                    r_d.addr = rx_byte[ADDR_W-1:0];
                    if (r_q.rd_cmd) begin
                        r_d.tx   = rd_data;
                        r_d.addr = rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                        r_d.ph   = PH_RDATA;
                    end else begin
                        r_d.ph   = PH_WDATA;
                    end
                end
                PH_RDATA: begin
                    r_d.tx   = rd_data;
                    r_d.addr = r_q.addr + ADDR_W'(1);
                end
                PH_WDATA: begin
                    r_d.pbuf[r_q.addr[PAGE_W-1:0]]   = rx_byte;
                    r_d.loaded[r_q.addr[PAGE_W-1:0]] = 1'b1;
                    r_d.addr = {r_q.addr[ADDR_W-1:PAGE_W], r_q.addr[PAGE_W-1:0] + PAGE_W'(1)};
                end
                PH_WSTAT: begin
                    r_d.sr_new    = rx_byte[3:2];
                    r_d.sr_loaded = 1'b1;
                end
                PH_RSTAT: r_d.tx = status_byte;
                default: ;
            endcase
        end

        if (cs_rise) begin
            r_d.ph = PH_OPC;
            if (commit_ok && r_q.ph == PH_WDATA && (|r_q.loaded)) begin
                commit  = 1'b1;
                r_d.wel = 1'b0;
            end else if (commit_ok && r_q.ph == PH_WSTAT && r_q.sr_loaded) begin
                commit    = 1'b1;
                r_d.wel   = 1'b0;
                r_d.field = r_q.sr_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_OPC;
            r_q.tx <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wel_now = r_q.wel;
    assign bp_now  = r_q.field;
endmodule

// File: rtl/spi_mem_chk.sv
`timescale 1ns/1ps
module spi_mem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       hold_n,
    input logic       wp_n,
    input logic       so_en,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp
);
    // R2: output enable is low once the deselect or pause has crossed the synchronizer
    a_r2_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n && $past(cs_n) && $past(cs_n, 2)) || (!hold_n && !$past(hold_n) && !$past(hold_n, 2)))
        |-> !so_en);

    // R6: a write cycle starts only with the latch set, and starting it clears the latch
    a_r6_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    a_r6_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel);

    // R10: no command can set the latch while the write cycle runs
    a_r10_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !$rose(wel));

    // R11: the protection field only moves together with a committed status write
    a_r11_field_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $rose(busy));

    // R12: a steady low write-protect pin never lets a write cycle start
    a_r12_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !$past(wp_n) && !$past(wp_n, 2) && !$past(wp_n, 3)) |-> !$rose(busy));
endmodule

bind spi_mem_slave spi_mem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .wp_n(wp_n),
    .so_en(so_en), .busy(busy), .wel(wel_now), .bp(bp_now)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
    localparam int WR   = 400;
    localparam int HALF = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;
    logic mode3 = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mm [256];
    logic [7:0] wbuf [8];
    logic wel_m = 1'b0, wp_m = 1'b1;
    logic [1:0] bp_m = 2'b00;

    always #2.5 clk = ~clk;

    spi_mem_slave #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic prot(input logic [7:0] a, input logic [1:0] f);
        return (f == 2'b11) || (f == 2'b10 && a[7]) || (f == 2'b01 && a[7:6] == 2'b11);
    endfunction

    task automatic set_mode(input logic m);
        mode3 = m;
        sck = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r, input int hold_at);
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                repeat (4) @(negedge clk);
                hold_n = 1'b0;
                repeat (4) @(negedge clk);
                chk("R2 so_en during hold", {7'd0, so_en}, 8'h00);
                for (int t = 0; t < 6; t++) begin
                    sck = ~sck; si = ~si;
                    repeat (3) @(negedge clk);
                end
                hold_n = 1'b1;
                repeat (4) @(negedge clk);
            end
            if (mode3) sck = 1'b0;
            si = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = so;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic tx1(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r, -1);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); tx1(op); cs_hi();
    endtask

    task automatic rdsr_chk(input string tag, input logic [7:0] exp);
        logic [7:0] r;
        cs_lo(); tx1(8'h05);
        xfer(8'h00, r, -1); chk(tag, r, exp);
        xfer(8'h00, r, -1); chk(tag, r, exp);
        cs_hi();
    endtask

    task automatic wait_idle();
        repeat (WR + 30) @(negedge clk);
    endtask

    task automatic latch_on();
        cmd1(8'h06);
        if (wp_m || 1'b1) wel_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] start, input int n);
        logic [7:0] pb [4];
        logic [3:0] ld;
        logic [1:0] off;
        cs_lo(); tx1(8'h02); tx1(start);
        for (int k = 0; k < n; k++) tx1(wbuf[k]);
        cs_hi();
        if (wel_m && wp_m) begin
            ld = 4'b0000;
            off = start[1:0];
            for (int k = 0; k < n; k++) begin
                pb[off] = wbuf[k];
                ld[off] = 1'b1;
                off = off + 2'd1;
            end
            for (int j = 0; j < 4; j++) begin
                logic [7:0] a;
                a = {start[7:2], 2'(j)};
                if (ld[j] && !prot(a, bp_m)) mm[a] = pb[j];
            end
            wel_m = 1'b0;
            wait_idle();
        end
    endtask

    task automatic do_wrsr(input logic [7:0] v);
        cs_lo(); tx1(8'h01); tx1(v); cs_hi();
        if (wel_m && wp_m) begin
            bp_m = v[3:2];
            wel_m = 1'b0;
            wait_idle();
        end
    endtask

    task automatic read_chk(input string tag, input logic [7:0] start, input int n);
        logic [7:0] r, a;
        cs_lo(); tx1(8'h03); tx1(start);
        for (int k = 0; k < n; k++) begin
            a = start + 8'(k);
            xfer(8'h00, r, -1);
            chk(tag, r, mm[a]);
        end
        cs_hi();
        chk("R2 so_en after deselect", {7'd0, so_en}, 8'h00);
    endtask

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 so_en at reset", {7'd0, so_en}, 8'h00);
        rdsr_chk("R1 R5 status at reset", 8'h00);
        read_chk("R1 erased array", 8'h00, 16);

        // R4 R6: latch set and clear opcodes
        latch_on();
        rdsr_chk("R6 latch set", 8'h02);
        cmd1(8'h04); wel_m = 1'b0;
        rdsr_chk("R6 latch cleared", 8'h00);

        // R6: write without latch does nothing
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h11 * 8'(k + 1);
        do_write(8'h10, 4);
        read_chk("R6 write without latch", 8'h10, 4);

        // R3 R8: full-array page sweep alternating modes 0 and 3
        for (int p = 0; p < 64; p++) begin
            set_mode(p[0]);
            latch_on();
            for (int k = 0; k < 4; k++) wbuf[k] = 8'(p * 4 + k) ^ 8'hA5;
            do_write(8'(p * 4), 4);
        end
        set_mode(1'b0);

        // R7: sequential read wraps past the top address
        read_chk("R7 read wrap", 8'hFE, 4);

        // R10: busy window, latch-set ignored during it
        latch_on();
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        cs_lo(); tx1(8'h02); tx1(8'h31); tx1(wbuf[0]); tx1(wbuf[1]); cs_hi();
        mm[8'h31] = wbuf[0]; mm[8'h32] = wbuf[1]; wel_m = 1'b0;
        rdsr_chk("R10 busy after commit", 8'h01);
        cmd1(8'h06);
        wait_idle();
        rdsr_chk("R10 latch-set ignored while busy", 8'h00);
        read_chk("R10 busy write data", 8'h30, 4);

        // R8: wrap within page and overwrite of repeated offsets
        latch_on();
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
        do_write(8'h23, 3);
        read_chk("R8 page wrap", 8'h20, 4);
        latch_on();
        for (int k = 0; k < 6; k++) wbuf[k] = 8'h70 + 8'(k);
        do_write(8'h40, 6);
        read_chk("R8 overwrite in page", 8'h40, 4);

        // R9: chip select rises mid-byte
        latch_on();
        cs_lo(); tx1(8'h02); tx1(8'h50); tx1(8'h99);
        for (int i = 7; i >= 5; i--) begin
            si = 1'b1; repeat (HALF) @(negedge clk);
            sck = 1'b1; repeat (HALF) @(negedge clk); sck = 1'b0;
        end
        cs_hi();
        rdsr_chk("R9 partial byte keeps latch, no busy", 8'h02);
        read_chk("R9 partial byte discarded", 8'h50, 4);

        // R4: unknown opcode swallows following bytes
        cmd1(8'h04); wel_m = 1'b0;
        cs_lo(); tx1(8'hAB); tx1(8'h06); cs_hi();
        rdsr_chk("R4 unknown opcode ignored", 8'h00);

        // R11 R5: protection levels
        for (int f = 1; f <= 3; f++) begin
            latch_on();
            do_wrsr({4'hF, 2'(f), 2'b11});
            rdsr_chk("R5 R11 field readback", {4'h0, 2'(f), 2'b00});
            for (int q = 0; q < 6; q++) begin
                logic [7:0] base;
                base = (q == 0) ? 8'h00 : (q == 1) ? 8'h7C : (q == 2) ? 8'h80 :
                       (q == 3) ? 8'hBC : (q == 4) ? 8'hC0 : 8'hFC;
                latch_on();
                for (int k = 0; k < 4; k++) wbuf[k] = 8'(f * 16 + q * 4 + k);
                do_write(base, 4);
                read_chk("R11 protected write", base, 4);
            end
        end
        latch_on();
        do_wrsr(8'h00);
        rdsr_chk("R11 field cleared", 8'h00);

        // R12: write-protect pin rejects both kinds of write
        wp_n = 1'b0; wp_m = 1'b0;
        repeat (4) @(negedge clk);
        latch_on();
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hE0 + 8'(k);
        do_write(8'h60, 4);
        rdsr_chk("R12 latch kept under wp", 8'h02);
        do_wrsr(8'h0C);
        rdsr_chk("R12 status write rejected", 8'h02);
        read_chk("R12 array unchanged", 8'h60, 4);
        wp_n = 1'b1; wp_m = 1'b1;
        cmd1(8'h04); wel_m = 1'b0;

        // R13: hold in the middle of address and data bytes, both modes
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            cs_lo(); tx1(8'h03);
            xfer(8'h20, r, 4);
            xfer(8'h00, r, 2);
            chk("R13 hold resumes read", r, mm[8'h20]);
            xfer(8'h00, r, 6);
            chk("R13 hold resumes next byte", r, mm[8'h21]);
            cs_hi();
        end
        set_mode(1'b1);
        latch_on();
        cs_lo(); tx1(8'h02); xfer(8'h88, r, 3); xfer(8'h5E, r, 5); cs_hi();
        mm[8'h88] = 8'h5E; wel_m = 1'b0;
        wait_idle();

        // R3 R7: final whole-array readback in mode 3
        read_chk("R7 final sweep", 8'h00, 256);
        summary();
    end
endmodule